// File: doc/BRIEF.md
# Five-Level H-Bridge Leg Gate Pattern Generator

This block drives one phase leg of a five-level H-bridge made of two three-level clamped half bridges, each with four gates numbered 1 to 4. Once per control period, marked by a strobe, it takes a signed level command, the sign of the phase current and a signed capacitor-imbalance indication, and registers the eight gate signals for that period. Levels +1 and -1 can each be produced by two switching modes, and each mode draws on only one of the two DC-link capacitors. The block picks the mode that pulls the capacitor voltages back toward balance.

Two fault masks report failed devices by gate index, one mask for devices that failed open and one for devices that failed short. While any fault bit is set, the level command is ignored and the leg is clamped at level 0, which ties its winding to the neutral point. Only the zero modes that every reported fault still allows are used. If the reported faults leave no usable zero mode, the block raises an unrecoverable flag and turns every gate off.

Top module: `hb5_gate_gen`

## Requirements
- R1: While reset is asserted, and after it until the first strobe, gates_o is 8'h66 (zero mode e) and unrecov_o is 0. The capacitor memory resets to "lower capacitor". Gate bit mapping: bits [3:0] are gates 1..4 of the first half bridge and bits [7:4] are gates 1..4 of the second.
- R2: gates_o and unrecov_o change only on the clock edge where strobe_i is 1, and take the value computed from the inputs at that edge.
- R3: With no fault, level +2 gives 8'hC3 and level -2 gives 8'h3C.
- R4: With no fault and a nonzero imbalance, the block uses the upper capacitor when (imbalance > 0) equals cur_pos_i, and the lower capacitor otherwise. Level +1 gives 8'h63 on the upper capacitor and 8'hC6 on the lower. Level -1 gives 8'h36 on the upper capacitor and 8'h6C on the lower. imbal_i is a 2-bit two's-complement value.
- R5: With imbalance 0, a ±1 level reuses the capacitor chosen at the last strobe that produced ±1. Strobes that produce any other output leave this memory unchanged.
- R6: With no fault, level 0 and the unused codes +3, -3 and -4 give zero mode e (8'h66).
- R7: When any bit of fault_open_i or fault_short_i is set, the level command is ignored. The leg uses a zero mode allowed by every set bit, preferring e, then d, then f. d = 8'h33, e = 8'h66, f = 8'hCC. Allowed sets by gate index 1/2/3/4: failed open {e,f}/{f}/{d}/{d,e}; failed short {d,f}/{d,e}/{e,f}/{d,f}.
- R8: If the intersection of the allowed sets is empty, unrecov_o is 1 and gates_o is 0. Otherwise unrecov_o is 0.
- R9: Whenever unrecov_o is 0, gate 1 is the complement of gate 3 and gate 2 is the complement of gate 4 in both half bridges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | Control-period strobe; outputs update on it |
| level_i | input | 3 | Signed level command, -2..+2 |
| cur_pos_i | input | 1 | 1 when phase current is positive |
| imbal_i | input | 2 | Signed imbalance; positive means the upper capacitor is high |
| fault_open_i | input | 4 | Bit k set: device with gate index k+1 failed open |
| fault_short_i | input | 4 | Bit k set: device with gate index k+1 failed short |
| gates_o | output | 8 | Registered gate pattern |
| unrecov_o | output | 1 | No usable zero mode under the reported faults |

## Verification
The capacitor-choice memory and the fault override can act in the same strobe. This happens when a fault arrives together with a ±1 command and a nonzero imbalance: the fault must win, and the memory must stay as it was. The bench provokes this with a directed sequence. It first sets a known memory value, then applies a faulted ±1 strobe with the opposite imbalance, then clears the fault and applies ±1 with zero imbalance; the expected mode comes from the bench's own memory. Random stimulus also mixes faulted strobes among balancing strobes, and the same model judges every strobe.

// File: rtl/hb5_pkg.sv
package hb5_pkg;
  typedef enum logic [1:0] {HB_P, HB_O, HB_N, HB_OFF} half_st_e;

  typedef enum logic [3:0] {
    MD_P2, MD_P1_C2, MD_P1_C1, MD_Z_D, MD_Z_E, MD_Z_F,
    MD_N1_C1, MD_N1_C2, MD_N2, MD_OFF
  } leg_mode_e;

  localparam int ZM_W = 3; // bit0 = d, bit1 = e, bit2 = f

  function automatic logic [ZM_W-1:0] open_allow(input int k);
    case (k)
      0:       return 3'b110;
      1:       return 3'b100;
      2:       return 3'b001;
      3:       return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

  function automatic logic [ZM_W-1:0] short_allow(input int k);
    case (k)
      0:       return 3'b101;
      1:       return 3'b011;
      2:       return 3'b110;
      3:       return 3'b101;
      default: return 3'b111;
    endcase
  endfunction

  function automatic half_st_e first_half(input leg_mode_e m);
    case (m)
      MD_P2, MD_P1_C1, MD_Z_D:   return HB_P;
      MD_P1_C2, MD_Z_E, MD_N1_C1: return HB_O;
      MD_Z_F, MD_N1_C2, MD_N2:   return HB_N;
      default:                   return HB_OFF;
    endcase
  endfunction

  function automatic half_st_e second_half(input leg_mode_e m);
    case (m)
      MD_N2, MD_N1_C1, MD_Z_D:   return HB_P;
      MD_P1_C1, MD_Z_E, MD_N1_C2: return HB_O;
      MD_Z_F, MD_P1_C2, MD_P2:   return HB_N;
      default:                   return HB_OFF;
    endcase
  endfunction
endpackage

// File: rtl/hb5_zero_sel.sv
module hb5_zero_sel
  import hb5_pkg::*;
#(
  parameter int NUM_DEV = 4
) (
  input  logic [NUM_DEV-1:0] fault_open_i,
  input  logic [NUM_DEV-1:0] fault_short_i,
  output logic               fault_any_o,
  output leg_mode_e          zmode_o,
  output logic               znone_o
);
  logic [ZM_W-1:0] dev_allow [NUM_DEV];
  logic [ZM_W-1:0] allow;

  for (genvar k = 0; k < NUM_DEV; k++) begin : g_dev
    assign dev_allow[k] = (fault_open_i[k]  ? open_allow(k)  : {ZM_W{1'b1}}) &
                          (fault_short_i[k] ? short_allow(k) : {ZM_W{1'b1}});
  end

  always_comb begin
    allow = {ZM_W{1'b1}};
    for (int k = 0; k < NUM_DEV; k++) allow &= dev_allow[k];
  end

  assign fault_any_o = |{fault_open_i, fault_short_i};

  // preference: e (lowest loss), then d, then f
  always_comb begin
    znone_o = 1'b0;
    if (allow[1])      zmode_o = MD_Z_E;
    else if (allow[0]) zmode_o = MD_Z_D;
    else if (allow[2]) zmode_o = MD_Z_F;
    else begin
      zmode_o = MD_OFF;
      znone_o = 1'b1;
    end
  end
endmodule

// File: rtl/hb5_mode_sel.sv
module hb5_mode_sel
  import hb5_pkg::*;
#(
  parameter int LVL_W = 3,
  parameter int IMB_W = 2
) (
  input  logic signed [LVL_W-1:0] level_i,
  input  logic                    cur_pos_i,
  input  logic signed [IMB_W-1:0] imbal_i,
  input  logic                    last_c1_i,
  input  logic                    fault_i,
  input  leg_mode_e               zmode_i,
  input  logic                    znone_i,
  output leg_mode_e               mode_o,
  output logic                    c1_o,
  output logic                    upd_o
);
  int   lv;
  logic imb_pos, imb_zero, sel_c1;

  always_comb begin
    lv       = int'(level_i);
    imb_zero = (imbal_i == '0);
    imb_pos  = !imbal_i[IMB_W-1] && !imb_zero;
    // discharging with positive current: use the high cap, else the low one
    sel_c1   = imb_zero ? last_c1_i : (imb_pos == cur_pos_i);
    upd_o    = 1'b0;
    c1_o     = last_c1_i;
    mode_o   = MD_Z_E;
    if (fault_i) begin
      mode_o = znone_i ? MD_OFF : zmode_i;
    end else begin
      case (lv)
        2:  mode_o = MD_P2;
        -2: mode_o = MD_N2;
        1: begin
          upd_o  = 1'b1;
          c1_o   = sel_c1;
          mode_o = sel_c1 ? MD_P1_C1 : MD_P1_C2;
        end
        -1: begin
          upd_o  = 1'b1;
          c1_o   = sel_c1;
          mode_o = sel_c1 ? MD_N1_C1 : MD_N1_C2;
        end
        default: mode_o = MD_Z_E;
      endcase
    end
  end
endmodule

// File: rtl/hb5_half_enc.sv
module hb5_half_enc
  import hb5_pkg::*;
(
  input  half_st_e    state_i,
  output logic [3:0]  gates_o  // bit0 = gate 1
);
  always_comb begin
    case (state_i)
      HB_P:    gates_o = 4'b0011;
      HB_O:    gates_o = 4'b0110;
      HB_N:    gates_o = 4'b1100;
      default: gates_o = 4'b0000;
    endcase
  end
endmodule

// File: rtl/hb5_gate_gen.sv
module hb5_gate_gen
  import hb5_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int LVL_W   = 3,
  parameter int IMB_W   = 2,
  parameter int NUM_HB  = 2,
  localparam int GATE_W = NUM_HB * NUM_DEV
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    strobe_i,
  input  logic signed [LVL_W-1:0] level_i,
  input  logic                    cur_pos_i,
  input  logic signed [IMB_W-1:0] imbal_i,
  input  logic [NUM_DEV-1:0]      fault_open_i,
  input  logic [NUM_DEV-1:0]      fault_short_i,
  output logic [GATE_W-1:0]       gates_o,
  output logic                    unrecov_o
);
  leg_mode_e         zmode, mode;
  logic              znone, fault_any, c1_next, upd;
  logic              last_c1_q;
  logic [GATE_W-1:0] gates_d, gates_q;
  half_st_e          half_st [NUM_HB];
  logic              unrecov_q;

  hb5_zero_sel #(.NUM_DEV(NUM_DEV)) i_zero_sel (
    .fault_open_i (fault_open_i),
    .fault_short_i(fault_short_i),
    .fault_any_o  (fault_any),
    .zmode_o      (zmode),
    .znone_o      (znone)
  );

  hb5_mode_sel #(.LVL_W(LVL_W), .IMB_W(IMB_W)) i_mode_sel (
    .level_i  (level_i),
    .cur_pos_i(cur_pos_i),
    .imbal_i  (imbal_i),
    .last_c1_i(last_c1_q),
    .fault_i  (fault_any),
    .zmode_i  (zmode),
    .znone_i  (znone),
    .mode_o   (mode),
    .c1_o     (c1_next),
    .upd_o    (upd)
  );

  assign half_st[0] = first_half(mode);
  assign half_st[1] = second_half(mode);

  for (genvar b = 0; b < NUM_HB; b++) begin : g_half
    hb5_half_enc i_half_enc (
      .state_i(half_st[b]),
      .gates_o(gates_d[b*NUM_DEV +: NUM_DEV])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gates_q   <= {NUM_HB{4'b0110}};
      unrecov_q <= 1'b0;
      last_c1_q <= 1'b0;
    end else if (strobe_i) begin
      gates_q   <= gates_d;
      unrecov_q <= (mode == MD_OFF);
      if (upd) last_c1_q <= c1_next;
    end
  end

  assign gates_o   = gates_q;
  assign unrecov_o = unrecov_q;
endmodule

// File: rtl/hb5_gate_gen_chk.sv
module hb5_gate_gen_chk #(
  parameter int NUM_DEV = 4,
  parameter int LVL_W   = 3,
  parameter int IMB_W   = 2,
  parameter int GATE_W  = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    strobe_i,
  input logic signed [LVL_W-1:0] level_i,
  input logic                    cur_pos_i,
  input logic signed [IMB_W-1:0] imbal_i,
  input logic [NUM_DEV-1:0]      fault_open_i,
  input logic [NUM_DEV-1:0]      fault_short_i,
  input logic [GATE_W-1:0]       gates_o,
  input logic                    unrecov_o
);
  logic no_fault;
  assign no_fault = !(|{fault_open_i, fault_short_i});

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(gates_o) && $stable(unrecov_o));

  assert_full_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && no_fault && level_i == 3'sd2 |=> gates_o == 8'hC3);

  assert_full_neg_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && no_fault && level_i == -3'sd2 |=> gates_o == 8'h3C);

  assert_balance_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && no_fault && level_i == 3'sd1 && imbal_i == 2'sd1 && cur_pos_i
    |=> gates_o == 8'h63);

  assert_fault_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && !no_fault |=> gates_o == 8'h33 || gates_o == 8'h66 ||
                              gates_o == 8'hCC || gates_o == 8'h00);

  assert_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unrecov_o |-> gates_o == '0);

  assert_compl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unrecov_o |-> gates_o[0] != gates_o[2] && gates_o[1] != gates_o[3] &&
                   gates_o[4] != gates_o[6] && gates_o[5] != gates_o[7]);
endmodule

bind hb5_gate_gen hb5_gate_gen_chk #(
  .NUM_DEV(NUM_DEV), .LVL_W(LVL_W), .IMB_W(IMB_W), .GATE_W(GATE_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe_i), .level_i(level_i),
  .cur_pos_i(cur_pos_i), .imbal_i(imbal_i), .fault_open_i(fault_open_i),
  .fault_short_i(fault_short_i), .gates_o(gates_o), .unrecov_o(unrecov_o)
);

// File: tb/test_hb5_gate_gen.sv
module test_hb5_gate_gen;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              strobe = 1'b0;
  logic signed [2:0] level = '0;
  logic              cur_pos = 1'b0;
  logic signed [1:0] imbal = '0;
  logic [3:0]        f_open = '0, f_short = '0;
  logic [7:0]        gates;
  logic              unrecov;

  int  checks = 0, errors = 0;
  bit  m_last = 1'b0;
  logic [7:0] exp_g = 8'h66;
  bit  exp_u = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hb5_gate_gen i_hb5_gate_gen (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .level_i(level),
    .cur_pos_i(cur_pos), .imbal_i(imbal), .fault_open_i(f_open),
    .fault_short_i(f_short), .gates_o(gates), .unrecov_o(unrecov)
  );

  function automatic logic [2:0] m_open(input int k);
    logic [2:0] t [4] = '{3'b110, 3'b100, 3'b001, 3'b011};
    return t[k];
  endfunction
  function automatic logic [2:0] m_short(input int k);
    logic [2:0] t [4] = '{3'b101, 3'b011, 3'b110, 3'b101};
    return t[k];
  endfunction

  // updates exp_g, exp_u, m_last
  task automatic model(input int lv, input bit cp, input int im,
                       input logic [3:0] op, input logic [3:0] sh);
    bit use_c1;
    logic [2:0] al;
    if (|{op, sh}) begin
      al = 3'b111;
      for (int k = 0; k < 4; k++) begin
        if (op[k]) al &= m_open(k);
        if (sh[k]) al &= m_short(k);
      end
      exp_u = 1'b0;
      if (al[1])      exp_g = 8'h66;
      else if (al[0]) exp_g = 8'h33;
      else if (al[2]) exp_g = 8'hCC;
      else begin exp_g = 8'h00; exp_u = 1'b1; end
    end else begin
      exp_u = 1'b0;
      use_c1 = (im == 0) ? m_last : ((im > 0) == cp);
      case (lv)
        2:  exp_g = 8'hC3;
        -2: exp_g = 8'h3C;
        1:  begin exp_g = use_c1 ? 8'h63 : 8'hC6; m_last = use_c1; end
        -1: begin exp_g = use_c1 ? 8'h36 : 8'h6C; m_last = use_c1; end
        default: exp_g = 8'h66;
      endcase
    end
  endtask

  task automatic check(input string tag);
    checks++;
    if (gates !== exp_g || unrecov !== exp_u) begin
      errors++;
      $display("FAIL %s gates=%h unrecov=%b expected gates=%h unrecov=%b",
               tag, gates, unrecov, exp_g, exp_u);
    end
    if (!unrecov && (gates[0] == gates[2] || gates[1] == gates[3] ||
                     gates[4] == gates[6] || gates[5] == gates[7])) begin
      checks++;
      errors++;
      $display("FAIL R9 gates=%h expected complementary pairs", gates);
    end
  endtask

  task automatic apply(input int lv, input bit cp, input int im,
                       input logic [3:0] op, input logic [3:0] sh,
                       input string tag);
    @(negedge clk);
    level = lv[2:0]; cur_pos = cp; imbal = im[1:0];
    f_open = op; f_short = sh; strobe = 1'b1;
    model(lv, cp, im, op, sh);
    @(negedge clk);
    strobe = 1'b0;
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired gates=%h expected completion", gates);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1 during reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after reset");

    // R2: input change without strobe has no effect
    level = 3'sd2; f_open = 4'b0101;
    repeat (4) @(negedge clk);
    check("R2 no strobe");

    apply(2, 0, 0, 4'h0, 4'h0, "R3 +2");
    apply(-2, 1, 0, 4'h0, 4'h0, "R3 -2");
    apply(1, 0, 0, 4'h0, 4'h0, "R5 reset memory lower cap");
    apply(1, 1, 1, 4'h0, 4'h0, "R4 +1 up pos");
    apply(1, 0, 1, 4'h0, 4'h0, "R4 +1 up neg");
    apply(-1, 1, -1, 4'h0, 4'h0, "R4 -1 low pos");
    apply(-1, 0, -1, 4'h0, 4'h0, "R4 -1 low neg");
    apply(-1, 1, -2, 4'h0, 4'h0, "R4 -1 imbal -2");
    apply(0, 1, 1, 4'h0, 4'h0, "R6 level 0");
    apply(3, 1, 0, 4'h0, 4'h0, "R6 code +3");
    apply(-3, 0, 0, 4'h0, 4'h0, "R6 code -3");
    apply(-4, 0, 1, 4'h0, 4'h0, "R6 code -4");
    apply(1, 0, 0, 4'h0, 4'h0, "R5 hold across other levels");
    // fault and memory in the same strobe
    apply(1, 1, 1, 4'h0, 4'h0, "R4 set upper");
    apply(-1, 0, 1, 4'b0100, 4'h0, "R7 fault with -1 command");
    apply(-1, 1, 0, 4'h0, 4'h0, "R5 memory kept over fault");
    for (int k = 0; k < 4; k++) begin
      apply(2, 1, 1, 4'(1 << k), 4'h0, "R7 single open");
      apply(-2, 0, 1, 4'h0, 4'(1 << k), "R7 single short");
    end
    apply(1, 1, 1, 4'b1000, 4'b0001, "R7 open4 short1 -> d");
    apply(2, 0, 0, 4'b0101, 4'h0, "R8 open1 open3 empty");
    repeat (3) @(negedge clk);
    check("R8 held without strobe");
    apply(0, 0, 0, 4'b0110, 4'h0, "R8 open2 open3 empty");
    apply(2, 0, 0, 4'h0, 4'h0, "R8 cleared");

    for (int n = 0; n < 400; n++) begin
      int lv, im;
      logic [3:0] op, sh;
      lv = int'($urandom % 8) - 4;
      im = int'($urandom % 4) - 2;
      op = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
      sh = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
      apply(lv, 1'($urandom), im, op, sh, "R4 R5 R7 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule